// File: doc/BRIEF.md
# Frequency Measurement Clock Counter

This block estimates the frequency of one of several clocks by counting that clock's rising edges inside a window of known length. A slower reference sets the window length. The counting logic runs on the selected clock itself. The window signal is brought into that domain through a two-flop synchronizer before its edges are detected.

Control logic in the system clock domain latches a configuration when it receives a start pulse. A toggle crosses into the measured domain to start the capture. When the window closes, a second toggle comes back to the control domain. That toggle loads the held count into an output register and raises `done`.

The window has two modes. In level mode, the window is open while the chosen trigger is high. In edge mode, the window runs from one rising edge of the trigger to a later rising edge, 1 to 32 trigger periods afterwards. A single general-purpose pin can serve either as the measured clock or as the trigger, but not as both in the same capture.

Top module: `fcc_meter`

## Requirements
- R1: After reset, `count` is 0 and `done`, `overflow` and `cfg_err` are all low.
- R2: With `level_mode`=0, the capture waits for the first rising edge of the synchronized trigger after start. It then counts source periods until the rising edge N periods later, where N = `win_len`+1 (0 gives 1, 31 gives 32). When the trigger edges fall away from source edges, the result is exactly N times the trigger period in source cycles.
- R3: With `level_mode`=1, `count` equals the number of source periods for which the trigger stays high. If the trigger is already high when the capture starts, that pulse is not counted; counting starts at the next low-to-high transition.
- R4: `src_sel` values 0 to NSRC-1 measure `src_clk[src_sel]`, and the value NSRC measures `ext_in`.
- R5: `trig_sel`=0 takes the window from `ref_in`, and `trig_sel`=1 takes it from `ext_in`.
- R6: A start with `src_sel`=NSRC and `trig_sel`=1 is rejected. It sets `cfg_err`, clears `count`, and leaves `done` low, because no capture runs.
- R7: The counter is CNT_W bits wide (22 by default). A count that would pass 2^CNT_W-1 stays at that value and `overflow` reads 1 with the result.
- R8: `done` rises once the window closes and the final value is in `count`. Both stay unchanged until the next accepted start, which clears `count`, `done`, `overflow` and `cfg_err`.
- R9: A start that arrives while a capture is running has no effect: the configuration and the result of the running capture are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control domain clock |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | NSRC | Candidate clocks to measure |
| ext_in | input | 1 | General pin, usable as clock or trigger |
| ref_in | input | 1 | Slow reference trigger |
| start | input | 1 | One-cycle start command |
| src_sel | input | SEL_W | Measured clock select |
| trig_sel | input | 1 | Trigger select: 0 reference, 1 pin |
| level_mode | input | 1 | 1 level window, 0 edge window |
| win_len | input | 5 | Edge-mode window length minus one |
| count | output | CNT_W | Captured count |
| done | output | 1 | Result valid |
| overflow | output | 1 | Count saturated |
| cfg_err | output | 1 | Start rejected for pin conflict |

## Verification
The bench places every trigger edge a quarter source period after a source edge. This makes the synchronizer latency identical at both ends of the window. A design that counted one extra or one missing cycle at either end, or that closed the edge window after N±1 periods, would then miss the exact products it expects. Those products include the one-period and the 32-period windows.

Several further cases are covered:
- A level pulse that is already high at start catches a design that opens the window partway through that pulse.
- A start issued mid-capture with a different configuration catches a design that restarts or switches clocks.
- A long pulse on a narrowed counter catches wrap-around instead of saturation.
- The pin-conflict start catches a design that runs a capture anyway.
- A per-clock monitor flags any change to `count` or `done` while a result is held.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
    localparam int MAX_PERIODS = 32;
    localparam int LEN_W       = $clog2(MAX_PERIODS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_COUNT
    } core_st_e;

    typedef struct packed {
        logic             level;
        logic             trig_ext;
        logic [LEN_W-1:0] len;
    } win_cfg_t;

    function automatic logic cfg_legal(input int sel, input logic trig_ext, input int nsrc);
        return (sel <= nsrc) && !((sel == nsrc) && trig_ext);
    endfunction
endpackage

// File: rtl/fcc_sync.sv
`timescale 1ns/1ps
module fcc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fcc_core.sv
`timescale 1ns/1ps
module fcc_core
    import fcc_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             sclk,
    input  logic             rst,
    input  logic             start_tgl,
    input  logic             trig,
    input  win_cfg_t         cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             done_tgl
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    core_st_e         state;
    logic             st_s, tr_s, st_d, tr_d;
    logic [LEN_W-1:0] nrise;
    logic             rise, fall, close;

    fcc_sync #(.W(2)) u_sync (
        .clk (sclk),
        .rst (rst),
        .d   ({start_tgl, trig}),
        .q   ({st_s, tr_s})
    );

    assign rise  = tr_s & ~tr_d;
    assign fall  = ~tr_s & tr_d;
    assign close = cfg.level ? fall : (rise && (nrise == cfg.len));

    always_ff @(posedge sclk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            ovf      <= 1'b0;
            done_tgl <= 1'b0;
            st_d     <= 1'b0;
            tr_d     <= 1'b0;
            nrise    <= '0;
        end else begin
            st_d <= st_s;
            tr_d <= tr_s;
            if (st_s != st_d) begin
                state <= ST_ARM;
                cnt   <= '0;
                ovf   <= 1'b0;
                nrise <= '0;
            end else begin
                case (state)
                    ST_ARM: begin
                        if (rise) begin
                            state <= ST_COUNT;
                            nrise <= '0;
                        end
                    end
                    ST_COUNT: begin
                        if (cnt == CNT_MAX) ovf <= 1'b1;
                        else                cnt <= cnt + 1'b1;
                        if (close) begin
                            state    <= ST_IDLE;
                            done_tgl <= ~done_tgl;
                        end else if (rise) begin
                            nrise <= nrise + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fcc_ctrl.sv
`timescale 1ns/1ps
module fcc_ctrl
    import fcc_pkg::*;
#(
    parameter int CNT_W = 22,
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             trig_sel,
    input  logic             level_mode,
    input  logic [LEN_W-1:0] win_len,
    input  logic [CNT_W-1:0] core_cnt,
    input  logic             core_ovf,
    input  logic             core_done_tgl,
    output logic [SEL_W-1:0] sel_q,
    output win_cfg_t         cfg_q,
    output logic             start_tgl,
    output logic             busy,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             overflow,
    output logic             cfg_err
);
    logic dt_s, dt_d;

    fcc_sync #(.W(1)) u_dsync (
        .clk (clk),
        .rst (rst),
        .d   (core_done_tgl),
        .q   (dt_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dt_d      <= 1'b0;
            sel_q     <= '0;
            cfg_q     <= '0;
            start_tgl <= 1'b0;
            busy      <= 1'b0;
            count     <= '0;
            done      <= 1'b0;
            overflow  <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            dt_d <= dt_s;
            if (dt_s != dt_d) begin
                done     <= 1'b1;
                busy     <= 1'b0;
                count    <= core_cnt;
                overflow <= core_ovf;
            end else if (start && !busy) begin
                done     <= 1'b0;
                overflow <= 1'b0;
                count    <= '0;
                if (cfg_legal(int'(src_sel), trig_sel, NSRC)) begin
                    cfg_err   <= 1'b0;
                    sel_q     <= src_sel;
                    cfg_q     <= '{level: level_mode, trig_ext: trig_sel, len: win_len};
                    start_tgl <= ~start_tgl;
                    busy      <= 1'b1;
                end else begin
                    cfg_err   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fcc_meter.sv
`timescale 1ns/1ps
module fcc_meter
    import fcc_pkg::*;
#(
    parameter int NSRC  = 3,
    parameter int CNT_W = 22,
    localparam int SEL_W = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_clk,
    input  logic             ext_in,
    input  logic             ref_in,
    input  logic             start,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             trig_sel,
    input  logic             level_mode,
    input  logic [LEN_W-1:0] win_len,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             overflow,
    output logic             cfg_err
);
    logic [SEL_W-1:0]      sel_q;
    win_cfg_t              cfg_q;
    logic                  start_tgl, busy;
    logic [CNT_W-1:0]      core_cnt;
    logic                  core_ovf, core_done_tgl;
    logic [2**SEL_W-1:0]   clk_pad;
    logic                  sclk, trig;

    always_comb begin
        clk_pad         = '0;
        clk_pad[NSRC:0] = {ext_in, src_clk};
    end

    assign sclk = clk_pad[sel_q];
    assign trig = cfg_q.trig_ext ? ext_in : ref_in;

    fcc_ctrl #(.CNT_W(CNT_W), .NSRC(NSRC), .SEL_W(SEL_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .src_sel       (src_sel),
        .trig_sel      (trig_sel),
        .level_mode    (level_mode),
        .win_len       (win_len),
        .core_cnt      (core_cnt),
        .core_ovf      (core_ovf),
        .core_done_tgl (core_done_tgl),
        .sel_q         (sel_q),
        .cfg_q         (cfg_q),
        .start_tgl     (start_tgl),
        .busy          (busy),
        .count         (count),
        .done          (done),
        .overflow      (overflow),
        .cfg_err       (cfg_err)
    );

    fcc_core #(.CNT_W(CNT_W)) u_core (
        .sclk      (sclk),
        .rst       (rst),
        .start_tgl (start_tgl),
        .trig      (trig),
        .cfg       (cfg_q),
        .cnt       (core_cnt),
        .ovf       (core_ovf),
        .done_tgl  (core_done_tgl)
    );
endmodule

// File: rtl/fcc_meter_chk.sv
`timescale 1ns/1ps
module fcc_meter_chk #(
    parameter int CNT_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             start_tgl,
    input logic [CNT_W-1:0] count,
    input logic             done,
    input logic             overflow,
    input logic             cfg_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(count));

    // R6
    err_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!done && !busy));

    // R7
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (count == CNT_MAX));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(start_tgl));
endmodule

bind fcc_meter fcc_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .start_tgl (start_tgl),
    .count     (count),
    .done      (done),
    .overflow  (overflow),
    .cfg_err   (cfg_err)
);

// File: tb/fcc_meter_tb.sv
`timescale 1ns/1ps
module fcc_meter_tb;
    localparam int NSRC  = 3;
    localparam int CNT_W = 12;

    logic        clk = 0, rst = 1;
    logic [2:0]  src_clk = '0;
    logic        ext_in = 0, ref_in = 0, start = 0;
    logic [1:0]  src_sel = '0;
    logic        trig_sel = 0, level_mode = 0;
    logic [4:0]  win_len = '0;
    logic [CNT_W-1:0] count;
    logic        done, overflow, cfg_err;

    int checks = 0, errors = 0;
    int tsel = 0, ref_half = 3;
    realtime qtr = 2.0;
    logic sck;
    logic hold_on = 0;
    logic [CNT_W-1:0] hold_val = '0;

    always #5   clk = ~clk;
    always #4   src_clk[0] = ~src_clk[0];
    always #7   src_clk[1] = ~src_clk[1];
    always #11  src_clk[2] = ~src_clk[2];

    always_comb begin
        case (tsel)
            0:       sck = src_clk[0];
            1:       sck = src_clk[1];
            default: sck = src_clk[2];
        endcase
    end

    fcc_meter #(.NSRC(NSRC), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .src_clk(src_clk), .ext_in(ext_in), .ref_in(ref_in),
        .start(start), .src_sel(src_sel), .trig_sel(trig_sel), .level_mode(level_mode),
        .win_len(win_len), .count(count), .done(done), .overflow(overflow), .cfg_err(cfg_err)
    );

    // reference trigger: rise-to-rise spacing is 2*ref_half selected source periods
    initial forever begin
        repeat (ref_half) @(posedge sck);
        #(qtr) ref_in = ~ref_in;
    end

    // held-result model: while a result is held, count and done must not move (R8)
    always @(negedge clk) begin
        if (hold_on && !start) begin
            checks++;
            if (count !== hold_val || done !== 1'b1) begin
                errors++;
                $display("FAIL R8 held result moved: count=%0d done=%0b expected count=%0d done=1",
                         count, done, hold_val);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pick_clock(input int s);
        tsel = s;
        qtr  = (s == 0) ? 2.0 : (s == 1) ? 3.5 : 5.5;
        repeat (40) @(negedge clk);
    endtask

    task automatic do_start(input int sel, input logic tsrc, input logic lvl, input int len);
        @(negedge clk);
        hold_on    = 0;
        src_sel    = sel[1:0];
        trig_sel   = tsrc;
        level_mode = lvl;
        win_len    = len[4:0];
        start      = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " done raised"}, int'(done), 1);
        hold_val = count;
        hold_on  = done;
    endtask

    task automatic ext_pulse(input int h);
        @(posedge sck);
        #(qtr) ext_in = 1;
        repeat (h) @(posedge sck);
        #(qtr) ext_in = 0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);

        // R2 shortest edge window: N=1, period 6
        ref_half = 3; pick_clock(0);
        do_start(0, 0, 0, 0);
        wait_done("R2 n1");
        chk("R2 N=1 count", int'(count), 6);

        // R2 longest edge window: N=32, period 4
        ref_half = 2; pick_clock(0);
        do_start(0, 0, 0, 31);
        wait_done("R2 n32");
        chk("R2 N=32 count", int'(count), 128);

        // R4 other source clock, period 10, N=5
        ref_half = 5; pick_clock(1);
        do_start(1, 0, 0, 4);
        wait_done("R4 src1");
        chk("R4 src1 count", int'(count), 50);

        // R3 R5 level window from the pin
        pick_clock(2);
        do_start(2, 1, 1, 0);
        repeat (20) @(negedge clk);
        ext_pulse(37);
        wait_done("R3 level");
        chk("R3 R5 pin level count", int'(count), 37);

        // R5 level window from reference: high for ref_half periods
        ref_half = 7; pick_clock(0);
        do_start(0, 0, 1, 0);
        wait_done("R5 ref level");
        chk("R5 ref level count", int'(count), 7);

        // R3 pulse already high at start is skipped
        pick_clock(2);
        @(posedge sck); #(qtr) ext_in = 1;
        do_start(2, 1, 1, 0);
        repeat (30) @(negedge clk);
        @(posedge sck); #(qtr) ext_in = 0;
        repeat (10) @(negedge clk);
        ext_pulse(20);
        wait_done("R3 prehigh");
        chk("R3 prehigh count", int'(count), 20);

        // R6 pin used as clock and trigger; R8 start clears done
        do_start(3, 1, 0, 0);
        @(negedge clk);
        chk("R6 cfg_err", int'(cfg_err), 1);
        chk("R6 R8 done cleared", int'(done), 0);
        chk("R6 count cleared", int'(count), 0);
        repeat (200) @(negedge clk);
        chk("R6 no capture done", int'(done), 0);

        // R9 start during capture ignored; R8 legal start clears cfg_err
        ref_half = 3; pick_clock(0);
        do_start(0, 0, 0, 9);
        @(negedge clk);
        chk("R8 cfg_err cleared", int'(cfg_err), 0);
        repeat (20) @(negedge clk);
        do_start(1, 0, 1, 0);
        wait_done("R9 busy");
        chk("R9 first capture kept", int'(count), 60);

        // R7 saturation
        pick_clock(0);
        do_start(0, 1, 1, 0);
        repeat (20) @(negedge clk);
        ext_pulse(5000);
        wait_done("R7 sat");
        chk("R7 saturated count", int'(count), 4095);
        chk("R7 overflow", int'(overflow), 1);

        // R8 next start clears overflow
        ref_half = 3; pick_clock(0);
        do_start(0, 0, 0, 0);
        @(negedge clk);
        chk("R8 overflow cleared", int'(overflow), 0);
        wait_done("R8 after sat");
        chk("R8 count after sat", int'(count), 6);
        chk("R7 overflow stays low", int'(overflow), 0);

        repeat (50) @(negedge clk);
        hold_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule